// File: doc/BRIEF.md
# Triggered Multichannel Pulse Capture Buffer

This block records short pulsed waveforms from six parallel ADC channels that all share one sample clock. It waits in an armed state until an external trigger rises. From then on it writes every channel's sample into that channel's own buffer on every clock, with all six channels advancing together. When the buffers are full, writing stops and the block moves straight into a drain phase.

In the drain phase the stored samples leave through one two-channel output. Channels 0 and 1 drain together first, then channels 2 and 3, then channels 4 and 5. Each beat carries the same sample index from both channels of the current pair. A valid/ready handshake paces the drain, so a slower downstream reader can stall it.

While it is capturing or draining, the block reports busy and ignores further triggers. After the final beat of the last pair it resets its pointers and re-arms. The trigger input may be asynchronous, and a synchronizer inside the block brings it into the sample-clock domain.

Top module: `pulse_capture_buf`

## Requirements
- R1: A single accepted trigger starts storage on all channels in the same cycle. For every channel, buffer index 0 holds the sample present on `adc_data` at the third rising clock edge after the first edge that sees `trig_in` high. Index i holds the sample present i edges later.
- R2: The trigger passes through a two-stage synchronizer, and only a rising edge is accepted. `busy` rises after the third clock edge that sees `trig_in` high, and not earlier. A trigger level held high across the return to armed starts no new capture.
- R3: Each channel stores exactly DEPTH samples (default 2048). `out_valid` stays low while the block is armed or capturing. It rises in the cycle after the last sample is written.
- R4: Trigger edges that arrive while the block is capturing or draining are ignored and leave no pending capture. `busy` is high and `armed` is low for that whole time.
- R5: Pairs drain in the fixed order 0, 1, 2, and `out_pair` (2 bits) shows the current pair. Pair p carries channels 2p and 2p+1.
- R6: `out_data[11:0]` holds the even channel's sample and `out_data[23:12]` holds the odd channel's sample, both taken from the same buffer index. Within a pair the indices go from 0 to DEPTH-1 in ascending order.
- R7: A beat is consumed only on a clock edge where `out_valid` and `out_ready` are both high. While the beat is stalled, `out_data`, `out_pair` and `out_last` hold their values.
- R8: `out_last` is high exactly on the beat at index DEPTH-1 of each pair.
- R9: After the last beat of pair 2 is consumed, the block is armed in the next cycle with `out_valid` low. The next capture stores again from index 0.
- R10: With `out_ready` held high, the block is armed again (1 + NUM_CH/2)·DEPTH + 3 clock edges after the first edge that sees the trigger high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous capture trigger |
| adc_data | input | 72 | Six 12-bit samples; channel c occupies bits [12c+11:12c] |
| out_valid | output | 1 | Drain beat available |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 24 | Pair sample: odd channel high, even channel low |
| out_pair | output | 2 | Index of the pair being drained |
| out_last | output | 1 | Final index of the current pair |
| busy | output | 1 | Capture or drain in progress |
| armed | output | 1 | Waiting for a trigger |

## Verification
Each channel is fed its own pseudo-random sample stream, with a fresh seed for every capture. Any mix-up of channel, pair, index or capture start offset therefore shows up as a data mismatch and not as a lucky match. Captures are drained with `out_ready` held high, which pins the exact turnaround time. They are also drained with `out_ready` random at several densities, which separates correct stall holding from skipped or repeated beats. Some captures receive trigger toggles during capture and drain. One capture keeps the trigger level high across re-arming, which separates edge detection from level sensing and shows whether a dropped edge is left pending.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
   typedef enum logic [1:0] {
      ST_ARMED   = 2'd0,
      ST_CAPTURE = 2'd1,
      ST_DRAIN   = 2'd2
   } cap_state_e;
endpackage

// File: rtl/pcb_trig_sync.sv
`timescale 1ns/1ps
module pcb_trig_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic trig_edge
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("pcb_trig_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // sh[SYNC_STAGES-1] is the synchronized level, sh[SYNC_STAGES] its delayed copy
   logic [SYNC_STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], trig_in};
   end

   assign trig_edge = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

   // R2: a held level yields one accepted edge only
   assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_edge |=> !trig_edge);
endmodule

// File: rtl/pcb_chan_buf.sv
`timescale 1ns/1ps
module pcb_chan_buf #(
   parameter int SAMPLE_W = 12,
   parameter int DEPTH    = 2048,
   localparam int PTR_W   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic [PTR_W-1:0]    wr_idx,
   input  logic [SAMPLE_W-1:0] wr_smp,
   input  logic [PTR_W-1:0]    rd_idx,
   output logic [SAMPLE_W-1:0] rd_smp
);
   logic [SAMPLE_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_idx] <= wr_smp;
   end

   assign rd_smp = store[rd_idx];
endmodule

// File: rtl/pcb_ctrl.sv
`timescale 1ns/1ps
module pcb_ctrl
   import pcb_pkg::*;
#(
   parameter int DEPTH    = 2048,
   parameter int NUM_PAIR = 3,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int PAIR_W  = (NUM_PAIR > 1) ? $clog2(NUM_PAIR) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_edge,
   input  logic              out_ready,
   output cap_state_e        state,
   output logic              wr_en,
   output logic [PTR_W-1:0]  wptr,
   output logic [PTR_W-1:0]  rptr,
   output logic [PAIR_W-1:0] rd_pair,
   output logic              out_valid,
   output logic              out_last
);
   localparam logic [PTR_W-1:0]  LAST_IDX  = PTR_W'(DEPTH - 1);
   localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIR - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_ARMED;
         wptr    <= '0;
         rptr    <= '0;
         rd_pair <= '0;
      end else begin
         case (state)
            ST_ARMED: begin
               if (trig_edge) begin
                  state <= ST_CAPTURE;
                  wptr  <= '0;
               end
            end
            ST_CAPTURE: begin
               wptr <= wptr + 1'b1;
               if (wptr == LAST_IDX) begin
                  state   <= ST_DRAIN;
                  wptr    <= '0;
                  rptr    <= '0;
                  rd_pair <= '0;
               end
            end
            ST_DRAIN: begin
               if (out_ready) begin
                  if (rptr == LAST_IDX) begin
                     rptr <= '0;
                     if (rd_pair == LAST_PAIR) begin
                        state   <= ST_ARMED;
                        rd_pair <= '0;
                     end else begin
                        rd_pair <= rd_pair + 1'b1;
                     end
                  end else begin
                     rptr <= rptr + 1'b1;
                  end
               end
            end
            default: state <= ST_ARMED;
         endcase
      end
   end

   assign wr_en     = (state == ST_CAPTURE);
   assign out_valid = (state == ST_DRAIN);
   assign out_last  = out_valid && (rptr == LAST_IDX);

   // R3: writing the last index ends capture and opens the drain
   assert_full_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPTURE && wptr == LAST_IDX) |=> (state == ST_DRAIN));

   // R4: a drain in progress never falls back into capture
   assert_no_retrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN) |=> (state != ST_CAPTURE));

   // R5: pair index stays in range and steps by one after each pair's last beat
   assert_pair_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (rd_pair <= LAST_PAIR));
   assert_pair_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last && rd_pair != LAST_PAIR)
      |=> (out_valid && rptr == '0 && rd_pair == PAIR_W'($past(rd_pair) + 1'b1)));

   // R9: final beat re-arms with pointers cleared
   assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last && rd_pair == LAST_PAIR)
      |=> (state == ST_ARMED && wptr == '0 && rptr == '0 && rd_pair == '0));
endmodule

// File: rtl/pulse_capture_buf.sv
`timescale 1ns/1ps
module pulse_capture_buf
   import pcb_pkg::*;
#(
   parameter int NUM_CH      = 6,
   parameter int SAMPLE_W    = 12,
   parameter int DEPTH       = 2048,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_PAIR   = NUM_CH / 2,
   localparam int PTR_W      = $clog2(DEPTH),
   localparam int PAIR_W     = (NUM_PAIR > 1) ? $clog2(NUM_PAIR) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         trig_in,
   input  logic [NUM_CH*SAMPLE_W-1:0]   adc_data,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [2*SAMPLE_W-1:0]        out_data,
   output logic [PAIR_W-1:0]            out_pair,
   output logic                         out_last,
   output logic                         busy,
   output logic                         armed
);
   generate
      if (NUM_CH < 2 || (NUM_CH % 2) != 0) begin : g_bad_ch
         $error("pulse_capture_buf: NUM_CH must be an even number of at least 2");
      end
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("pulse_capture_buf: DEPTH must be a power of two of at least 2");
      end
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("pulse_capture_buf: SAMPLE_W must be positive");
      end
   endgenerate

   logic              trig_edge;
   cap_state_e        state;
   logic              wr_en;
   logic [PTR_W-1:0]  wptr;
   logic [PTR_W-1:0]  rptr;
   logic [SAMPLE_W-1:0]   rd_smp    [NUM_CH];
   logic [2*SAMPLE_W-1:0] pair_word [NUM_PAIR];

   pcb_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_in   (trig_in),
      .trig_edge (trig_edge)
   );

   pcb_ctrl #(.DEPTH(DEPTH), .NUM_PAIR(NUM_PAIR)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_edge (trig_edge),
      .out_ready (out_ready),
      .state     (state),
      .wr_en     (wr_en),
      .wptr      (wptr),
      .rptr      (rptr),
      .rd_pair   (out_pair),
      .out_valid (out_valid),
      .out_last  (out_last)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pcb_chan_buf #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_buf (
            .clk    (clk),
            .wr_en  (wr_en),
            .wr_idx (wptr),
            .wr_smp (adc_data[c*SAMPLE_W +: SAMPLE_W]),
            .rd_idx (rptr),
            .rd_smp (rd_smp[c])
         );
      end
      for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
         assign pair_word[p] = {rd_smp[2*p+1], rd_smp[2*p]};
      end
   endgenerate

   always_comb begin
      out_data = '0;
      for (int p = 0; p < NUM_PAIR; p++) begin
         if (out_pair == PAIR_W'(p)) out_data = pair_word[p];
      end
   end

   assign busy  = (state != ST_ARMED);
   assign armed = (state == ST_ARMED);

   // R7: a stalled beat stays put
   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_pair) && $stable(out_last)));

   // R3: no beat is offered before the buffers are full
   assert_quiet_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wptr != PTR_W'(DEPTH - 1)) |=> !out_valid);
endmodule

// File: tb/pulse_capture_buf_tb.sv
`timescale 1ns/1ps
module pulse_capture_buf_tb;
   localparam int  CLK_PERIOD = 10;
   localparam int  NCH  = 6;
   localparam int  SW   = 12;
   localparam int  D    = 32;
   localparam int  NP   = NCH / 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              trig_in = 1'b0;
   logic [NCH*SW-1:0] adc_data;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [2*SW-1:0]   out_data;
   logic [1:0]        out_pair;
   logic              out_last;
   logic              busy;
   logic              armed;

   int unsigned scnt = 0;
   int unsigned pcnt = 0;
   int unsigned seed = 0;
   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(negedge clk) scnt <= scnt + 1;
   always @(posedge clk) pcnt <= pcnt + 1;

   function automatic logic [SW-1:0] pat(int unsigned c, int unsigned n, int unsigned s);
      bit [31:0] v;
      v = n * 32'd37 + c * 32'd1031 + s;
      v = v ^ (n >> 2) ^ (s >> 5);
      return v[SW-1:0];
   endfunction

   always_comb begin
      for (int c = 0; c < NCH; c++) adc_data[c*SW +: SW] = pat(c, scnt, seed);
   end

   pulse_capture_buf #(.NUM_CH(NCH), .SAMPLE_W(SW), .DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .adc_data(adc_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_pair(out_pair), .out_last(out_last), .busy(busy), .armed(armed)
   );

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   // one trigger, full capture and drain; pct = ready density, noisy = trigger toggles while busy
   task automatic run_capture(int unsigned s, int pct, bit noisy, bit hold);
      int unsigned t0, p0, p, i;
      bit stalled;
      string tag;
      logic [2*SW-1:0] exp;
      seed = s;
      repeat (4) step();
      check(armed && !busy, "R9", "armed before trigger", {armed, busy}, 2'b10);
      t0 = scnt;
      p0 = pcnt;
      trig_in = 1'b1;
      repeat (2) step();
      check(!busy, "R2", "busy too early", busy, 0);
      step();
      check(busy && !armed, "R4", "busy after third edge", {busy, armed}, 2'b10);
      trig_in = hold;
      for (int k = 3; k <= 1 + D; k++) begin
         step();
         if (noisy) trig_in = $urandom % 2;
      end
      check(!out_valid, "R3", "valid during capture", out_valid, 0);
      step();
      check(out_valid && out_pair == 0, "R3", "drain start", {out_valid, out_pair}, 3'b100);
      p = 0; i = 0; stalled = 1'b0;
      while (p < NP) begin
         exp = {pat(2*p+1, t0 + 3 + i, s), pat(2*p, t0 + 3 + i, s)};
         if (stalled)                tag = "R7";
         else if (p == 0 && i == 0)  tag = "R1";
         else if (i == 0)            tag = "R5";
         else if (i == D - 1)        tag = "R8";
         else                        tag = "R6";
         check(out_valid && out_data == exp && out_pair == p[1:0] && out_last == (i == D - 1),
               tag, $sformatf("beat pair %0d idx %0d {valid,pair,last,data}", p, i),
               {out_valid, out_pair, out_last, out_data},
               {1'b1, p[1:0], (i == D - 1), exp});
         if (noisy && (NP - 1 - p) * D + (D - 1 - i) > 8) trig_in = $urandom % 2;
         else trig_in = hold;
         out_ready = (pct >= 100) || (($urandom % 100) < pct);
         check(busy, "R4", "busy during drain", busy, 1);
         stalled = !out_ready;
         if (out_ready) begin
            i++;
            if (i == D) begin i = 0; p++; end
         end
         step();
      end
      out_ready = 1'b0;
      check(armed && !busy && !out_valid, "R9", "re-armed after final beat",
            {armed, busy, out_valid}, 3'b100);
      if (pct >= 100)
         check(pcnt - p0 == 3 + (1 + NP) * D, "R10", "turnaround edges", pcnt - p0, 3 + (1 + NP) * D);
      repeat (10) step();
      check(armed && !busy, hold ? "R2" : "R4", "no capture without a fresh edge",
            {armed, busy}, 2'b10);
      trig_in = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) step();
      check(armed && !busy && !out_valid, "R9", "reset state", {armed, busy, out_valid}, 3'b100);
      rst_n = 1'b1;
      step();
      check(armed && !busy && !out_valid, "R3", "armed and quiet after reset",
            {armed, busy, out_valid}, 3'b100);
      run_capture($urandom, 100, 1'b0, 1'b1);   // directed: ready high, trigger held
      run_capture($urandom, 100, 1'b1, 1'b0);   // directed: ready high, noisy trigger
      for (int n = 0; n < 6; n++) begin
         run_capture($urandom, 20 + 15 * n, n[0], 1'b0);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule